// File: doc/BRIEF.md
# Prescaled Event Timer

The block is an 8-bit up-counter that a host bus loads and reads back at any time. It advances either on a one-cycle instruction tick supplied by the core (timer mode) or on edges of an asynchronous external pin (counter mode). In counter mode the pin is first brought into the clock domain by a two-flop synchronizer, and a control bit picks the rising or the falling edge.

A power-of-two prescaler can sit between the selected source and the counter, dividing it by 2 up to 256. A control bit can instead route the undivided source straight to the counter. The selected pulse then passes through a two-stage delay before it can advance the count.

A host write to the count holds the counter still for the next two cycles and clears the hidden prescaler count. When the count wraps from FFh to 00h, a sticky flag is raised. An enable bit lets that flag reach the interrupt output. A sleep input stops all counting.

Top module: `evt_timer`

## Requirements
- R1: After a synchronous reset, `cnt_o` is 00h, `flag_o` and `irq_o` are 0, and `ctl_o` is 04h. In that state the prescaler is bypassed, the tick source is selected, and interrupts are disabled.
- R2: Writing the count loads `cnt_wdata_i` in the next cycle. Control fields read back on `ctl_o` are laid out as follows: bit 0 selects the source (0 = tick, 1 = pin), bit 1 selects the edge (0 = rising, 1 = falling), bit 2 bypasses the prescaler (1 = bypass), bits 5:3 hold the ratio code f, and bit 6 is the interrupt enable.
- R3: In timer mode with the prescaler bypassed and `tick_i` held high, the count reads W + k − 2 (modulo 256) at k ≥ 2 cycles after a write of W. The count never changes by more than +1 in a cycle without a write.
- R4: With the prescaler in use, the ratio is 2^(f+1). With `tick_i` held high, the count reads W + floor((k − 2) / 2^(f+1)) at k ≥ 2 cycles after a write of W, because the write also empties the prescaler.
- R5: For the two cycles that follow a count write, the count shows the written value unchanged.
- R6: In pin mode with the rising edge selected, each low-to-high change of `ext_i` advances the count by exactly one, at most five cycles later. Falling changes of `ext_i` and the level of `tick_i` have no effect.
- R7: In pin mode with the falling edge selected, only high-to-low changes of `ext_i` advance the count.
- R8: A wrap from FFh to 00h sets `flag_o`. The flag stays set until `flag_clr_i` is asserted. If a wrap and a clear fall in the same cycle, the wrap wins.
- R9: `irq_o` is high exactly when `flag_o` is high and the interrupt enable (bit 6) is set.
- R10: While `sleep_i` is high, the count does not advance. Counting resumes once `sleep_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Instruction-cycle tick, timer-mode source |
| ext_i | input | 1 | Asynchronous external count pin |
| sleep_i | input | 1 | Halts all counting while high |
| cnt_we_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | 8 | Count write data |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 7 | Control write data |
| flag_clr_i | input | 1 | Clears the overflow flag |
| cnt_o | output | 8 | Current count |
| ctl_o | output | 7 | Control fields read back |
| flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The edge-spacing property assumes that the edge-select bit is not flipped in the same cycle in which a synchronized edge is pending. The rest of the properties assume only that the strobes are clean single-cycle or level signals. The bench changes the control word only while the pin is idle, holds `ext_i` low through reset so that no edge appears at release, and keeps each pin level for three cycles so that every change crosses the synchronizer. All inputs are driven on the falling clock edge. The tick is held steady across each measured window, so the expected counts follow in closed form from R3 and R4.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam int PS_SEL_W = 3;
  localparam int PS_CNT_W = 1 << PS_SEL_W;

  // control word, MSB first: enable, ratio code, bypass, edge, source
  typedef struct packed {
    logic                irq_en;
    logic [PS_SEL_W-1:0] ps_sel;
    logic                ps_bypass;
    logic                edge_fall;
    logic                src_ext;
  } ctl_t;

  localparam int   CTL_W     = $bits(ctl_t);
  localparam ctl_t CTL_RESET = '{irq_en: 1'b0, ps_sel: '0, ps_bypass: 1'b1,
                                 edge_fall: 1'b0, src_ext: 1'b0};

endpackage

// File: rtl/evt_timer_insync.sv
module evt_timer_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);

  // STAGES flops for metastability, one more to remember the last level
  logic [STAGES:0] sh_q;
  logic            rise, fall;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise   =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall   = ~sh_q[STAGES-1] &  sh_q[STAGES];
  assign edge_o = fall_sel_i ? fall : rise;

  // a same-type edge can never be seen in two consecutive cycles
  AST_EDGE_SPACING: assert property (@(posedge clk) disable iff (rst)
    edge_o ##1 $stable(fall_sel_i) |-> !edge_o); // R6

endmodule

// File: rtl/evt_timer_presc.sv
module evt_timer_presc #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             bypass_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             src_i,
  output logic             pulse_o
);

  localparam int CW = 1 << SEL_W;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] mask;

  // mask has sel_i+1 low ones, so the ratio is 2^(sel_i+1)
  for (genvar g = 0; g < CW; g++) begin : g_mask
    localparam logic [SEL_W:0] GIDX = (SEL_W+1)'(g);
    assign mask[g] = (GIDX <= {1'b0, sel_i});
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i)             cnt_q <= '0;
    else if (src_i && !bypass_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign pulse_o = bypass_i ? src_i : (src_i && ((cnt_q & mask) == mask));

  // with division active, output pulses are at least two cycles apart
  AST_PS_SPACING: assert property (@(posedge clk) disable iff (rst)
    pulse_o && !bypass_i |=> (!pulse_o || bypass_i)); // R4

endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
  parameter int CNT_W    = 8,
  parameter int DELAY    = 2,
  parameter int HOLD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  input  logic             sleep_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);

  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [DELAY-1:0] pipe_q;
  logic [HW-1:0]    hold_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             inc, wrap;

  // resynchronizing delay between the source pulse and the counter
  if (DELAY == 1) begin : g_dly1
    always_ff @(posedge clk) begin
      if (rst) pipe_q <= '0;
      else     pipe_q <= adv_i;
    end
  end else begin : g_dlyn
    always_ff @(posedge clk) begin
      if (rst) pipe_q <= '0;
      else     pipe_q <= {pipe_q[DELAY-2:0], adv_i};
    end
  end

  // write hold-off window
  always_ff @(posedge clk) begin
    if (rst)              hold_q <= '0;
    else if (wr_i)        hold_q <= HW'(HOLD_CYC);
    else if (hold_q != 0) hold_q <= hold_q - 1'b1;
  end

  assign inc  = pipe_q[DELAY-1] && (hold_q == 0) && !sleep_i && !wr_i;
  assign wrap = inc && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (wr_i) cnt_q <= wdata_i;
    else if (inc)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)             flag_q <= 1'b0;
    else if (wrap)       flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  AST_WR_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> cnt_q == $past(wdata_i)); // R2
  AST_WR_HOLD1: assert property (@(posedge clk) disable iff (rst)
    wr_i ##1 !wr_i |=> $stable(cnt_q)); // R5
  AST_WR_HOLD2: assert property (@(posedge clk) disable iff (rst)
    wr_i ##1 !wr_i ##1 !wr_i |=> $stable(cnt_q)); // R5
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    sleep_i && !wr_i |=> $stable(cnt_q)); // R10
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R3
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
    !wr_i && cnt_q == '1 ##1 cnt_q == '0 |-> flag_q); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    flag_q && !flag_clr_i |=> flag_q); // R8

endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int DELAY_STAGES = 2,
  parameter int HOLD_CYC     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             ext_i,
  input  logic             sleep_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             flag_o,
  output logic             irq_o
);

  ctl_t ctl_q;
  logic pin_edge;
  logic src_raw, src_gated;
  logic ps_pulse;
  logic flag;

  always_ff @(posedge clk) begin
    if (rst)           ctl_q <= CTL_RESET;
    else if (ctl_we_i) ctl_q <= ctl_t'(ctl_wdata_i);
  end

  evt_timer_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .pin_i      (ext_i),
    .fall_sel_i (ctl_q.edge_fall),
    .edge_o     (pin_edge)
  );

  assign src_raw   = ctl_q.src_ext ? pin_edge : tick_i;
  assign src_gated = src_raw && !sleep_i;

  evt_timer_presc #(.SEL_W(PS_SEL_W)) u_presc (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (cnt_we_i),
    .bypass_i (ctl_q.ps_bypass),
    .sel_i    (ctl_q.ps_sel),
    .src_i    (src_gated),
    .pulse_o  (ps_pulse)
  );

  evt_timer_core #(
    .CNT_W    (CNT_W),
    .DELAY    (DELAY_STAGES),
    .HOLD_CYC (HOLD_CYC)
  ) u_core (
    .clk        (clk),
    .rst        (rst),
    .adv_i      (ps_pulse),
    .sleep_i    (sleep_i),
    .wr_i       (cnt_we_i),
    .wdata_i    (cnt_wdata_i),
    .flag_clr_i (flag_clr_i),
    .cnt_o      (cnt_o),
    .flag_o     (flag)
  );

  assign ctl_o  = ctl_q;
  assign flag_o = flag;
  assign irq_o  = flag && ctl_q.irq_en;

endmodule

// File: tb/sim_evt_timer.sv
module sim_evt_timer;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  // {ctl, start, wait cycles, expected count}; tick held high throughout
  localparam logic [39:0] VEC [0:NVEC-1] = '{
    {8'h04, 8'h00, 16'd10,  8'h08},  // R3 bypass
    {8'h04, 8'h10, 16'd2,   8'h10},  // R5 still inside hold-off
    {8'h04, 8'h10, 16'd3,   8'h11},  // R3 first increment
    {8'h00, 8'h00, 16'd20,  8'h09},  // R4 ratio 2
    {8'h08, 8'h00, 16'd20,  8'h04},  // R4 ratio 4
    {8'h10, 8'h00, 16'd34,  8'h04},  // R4 ratio 8
    {8'h38, 8'h00, 16'd257, 8'h00},  // R4 ratio 256, just short
    {8'h38, 8'h00, 16'd258, 8'h01},  // R4 ratio 256, first step
    {8'h04, 8'hFE, 16'd5,   8'h01},  // R3 wrap through zero
    {8'h18, 8'h40, 16'd50,  8'h43}   // R4 ratio 16
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b1;
  logic       ext_i = 1'b0;
  logic       sleep_i = 1'b0;
  logic       cnt_we_i = 1'b0;
  logic [7:0] cnt_wdata_i = '0;
  logic       ctl_we_i = 1'b0;
  logic [6:0] ctl_wdata_i = '0;
  logic       flag_clr_i = 1'b0;
  logic [7:0] cnt_o;
  logic [6:0] ctl_o;
  logic       flag_o, irq_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_timer u0 (
    .clk(clk), .rst(rst), .tick_i(tick_i), .ext_i(ext_i), .sleep_i(sleep_i),
    .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i), .ctl_we_i(ctl_we_i),
    .ctl_wdata_i(ctl_wdata_i), .flag_clr_i(flag_clr_i), .cnt_o(cnt_o),
    .ctl_o(ctl_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [6:0] v);
    ctl_we_i = 1'b1; ctl_wdata_i = v;
    cyc(1);
    ctl_we_i = 1'b0;
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    cnt_we_i = 1'b1; cnt_wdata_i = v;
    cyc(1);
    cnt_we_i = 1'b0;
  endtask

  task automatic clr_flag();
    flag_clr_i = 1'b1;
    cyc(1);
    flag_clr_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    chk("R1 count after reset", cnt_o, 8'h00);
    chk("R1 control after reset", ctl_o, 7'h04);
    chk("R1 flag after reset", flag_o, 1'b0);
    chk("R1 irq after reset", irq_o, 1'b0);

    // R2 control layout read-back
    wr_ctl(7'h5A);
    chk("R2 control read-back", ctl_o, 7'h5A);

    // vector table: R3, R4, R5
    for (int i = 0; i < NVEC; i++) begin
      wr_ctl(VEC[i][38:32]);
      cyc(3);
      wr_cnt(VEC[i][31:24]);
      cyc(int'(VEC[i][23:8]));
      chk($sformatf("R3/R4/R5 vector %0d", i), cnt_o, VEC[i][7:0]);
    end

    // R2 direct load
    wr_ctl(7'h04);
    tick_i = 1'b0;
    cyc(4);
    wr_cnt(8'hA5);
    chk("R2 count load", cnt_o, 8'hA5);

    // R10 sleep
    tick_i = 1'b1;
    wr_cnt(8'h20);
    cyc(5);
    sleep_i = 1'b1;
    cyc(10);
    chk("R10 held during sleep", cnt_o, 8'h23);
    sleep_i = 1'b0;
    cyc(10);
    chk("R10 resumes after sleep", cnt_o, 8'h2B);

    // R6 rising edges, tick ignored
    wr_ctl(7'h05);
    cyc(4);
    wr_cnt(8'h00);
    cyc(5);
    chk("R6 tick ignored in pin mode", cnt_o, 8'h00);
    ext_i = 1'b1;
    cyc(10);
    chk("R6 rise counted", cnt_o, 8'h01);
    ext_i = 1'b0;
    cyc(10);
    chk("R6 fall ignored", cnt_o, 8'h01);
    for (int p = 0; p < 5; p++) begin
      ext_i = 1'b1; cyc(3);
      ext_i = 1'b0; cyc(3);
    end
    cyc(10);
    chk("R6 pulse train", cnt_o, 8'h06);

    // R7 falling edges
    wr_ctl(7'h07);
    cyc(4);
    wr_cnt(8'h00);
    cyc(5);
    ext_i = 1'b1;
    cyc(10);
    chk("R7 rise ignored", cnt_o, 8'h00);
    ext_i = 1'b0;
    cyc(10);
    chk("R7 fall counted", cnt_o, 8'h01);

    // R8, R9 overflow flag and interrupt
    wr_ctl(7'h04);
    clr_flag();
    chk("R8 flag cleared", flag_o, 1'b0);
    cyc(3);
    wr_cnt(8'hFF);
    cyc(3);
    chk("R8 wrap sets flag", flag_o, 1'b1);
    tick_i = 1'b0;
    cyc(5);
    chk("R8 flag sticky", flag_o, 1'b1);
    chk("R9 irq masked", irq_o, 1'b0);
    wr_ctl(7'h44);
    chk("R9 irq enabled", irq_o, 1'b1);
    clr_flag();
    chk("R8 flag clear", flag_o, 1'b0);
    chk("R9 irq drops with flag", irq_o, 1'b0);

    // R8 wrap wins over a simultaneous clear
    tick_i = 1'b1;
    cyc(3);
    flag_clr_i = 1'b1;
    wr_cnt(8'hFF);
    cyc(3);
    chk("R8 set beats clear", flag_o, 1'b1);
    cyc(1);
    chk("R8 clear applies next cycle", flag_o, 1'b0);
    flag_clr_i = 1'b0;
    cyc(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule